// File: doc/BRIEF.md
# MDIO Management Slave

This block is the PHY side of a two-wire serial management link. A station drives a management clock and a bidirectional data line; the slave follows both through a small synchroniser running on its own system clock, decodes each frame (preamble, start, opcode, PHY address, register address, turnaround, data) and gives the station read and write access to a bank of 16-bit management registers. The parameter `IMPL_MASK` selects which of the 32 register addresses exist. All registers reset to `RST_VAL`.

The slave drives the data line only in the second half of a read turnaround and during the read data that follows. It does this through `mdio_oe` and `mdio_o`, and the pad combines the two with the station's driver and a pull-up. At every other time the line is left to the station. Frames may follow one another with no idle bit between them.

Top module: `mdio_slv_top`

## Requirements
- R1: A read frame (opcode bits 1 then 0) whose PHY address matches `phy_addr_i` returns the addressed register in the 16 data bit times, most significant bit first. Each bit is set up after a management clock rising edge, so it is stable at the next rising edge.
- R2: A write frame (opcode bits 0 then 1) whose PHY address matches stores the 16 data bits, sent most significant bit first, in the addressed implemented register.
- R3: In a matching read, `mdio_oe` is low during the first turnaround bit. It is high with `mdio_o` low during the second turnaround bit.
- R4: During a write frame the slave never drives the line, whatever the station sends as turnaround.
- R5: A read of an address whose `IMPL_MASK` bit is clear returns 16'hFFFF. The default mask implements addresses 0 to 3 and 15.
- R6: A write to an unimplemented address leaves every register unchanged.
- R7: A frame whose PHY address differs from `phy_addr_i` causes no drive on the line, and a write in such a frame changes no register.
- R8: A frame is recognised only after at least 32 consecutive ones, then the start bits 0 and 1. A frame preceded by 31 ones is ignored.
- R9: A wrong second start bit, or an opcode of 00 or 11, ends the frame. The slave then drives nothing, writes nothing and returns to looking for a preamble.
- R10: A frame that starts in the bit time right after the last data bit of the previous frame is decoded normally. After a read, the line is released before the next frame's first bit.
- R11: After reset `mdio_oe` is low and every implemented register holds `RST_VAL` (default 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Data line value seen at the pad |
| phy_addr_i | input | 5 | Address this slave answers to |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The bench sends 31-one preambles. A slave that counts ones carelessly would accept such a frame and store its data. It sends opcodes 00 and 11 and a bad start bit; a slave that misses these would drive the line or corrupt a register. It writes to an unimplemented address and then reads back every implemented register, which catches address decode that aliases onto a real register. Most frames are sent back to back, so a slave that needs an idle bit would miss every second frame. Read data is compared word by word, which exposes a turnaround that is one bit early or late as a shifted value.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    localparam int DW      = 16;
    localparam int AW      = 5;
    localparam int NREG    = 1 << AW;
    localparam int PRE_LEN = 32;
    localparam int PCW     = $clog2(PRE_LEN + 1);
    localparam int BCW     = $clog2(DW);

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } mdio_st_e;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } mdio_wr_t;

    function automatic logic addr_impl(input logic [NREG-1:0] mask, input logic [AW-1:0] a);
        return mask[a];
    endfunction

endpackage

// File: rtl/mdio_slv_sync.sv
module mdio_slv_sync (
    input  logic clk,
    input  logic rst,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic din_o
);
    logic [2:0] mdc_q;
    logic [1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q <= '0;
            dat_q <= '0;
        end else begin
            mdc_q <= {mdc_q[1:0], mdc_i};
            dat_q <= {dat_q[0], mdio_i};
        end
    end

    assign rise_o = mdc_q[1] & ~mdc_q[2];
    assign din_o  = dat_q[1];
endmodule

// File: rtl/mdio_slv_regs.sv
module mdio_slv_regs
    import mdio_slv_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 32'h0000_800F,
    parameter logic [DW-1:0]   RST_VAL   = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  mdio_wr_t      wr_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [NREG*DW-1:0] flat;

    for (genvar a = 0; a < NREG; a++) begin : g_reg
        if (IMPL_MASK[a]) begin : g_impl
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= RST_VAL;
                else if (wr_i.en && wr_i.addr == AW'(a))
                    q <= wr_i.data;
            end
            assign flat[a*DW +: DW] = q;
        end else begin : g_none
            assign flat[a*DW +: DW] = '1;
        end
    end

    assign rdata_o = flat[raddr_i*DW +: DW];
endmodule

// File: rtl/mdio_slv_fsm.sv
module mdio_slv_fsm
    import mdio_slv_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 32'h0000_800F
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    input  logic          din_i,
    input  logic [AW-1:0] phy_addr_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] raddr_o,
    output mdio_wr_t      wr_o,
    output logic          mdio_o,
    output logic          mdio_oe,
    output mdio_st_e      state_o,
    output logic          rd_o,
    output logic          hit_o
);
    mdio_st_e       st;
    logic [PCW-1:0] pre_cnt;
    logic [BCW-1:0] bit_cnt;
    logic [DW-1:0]  sh;
    logic [DW-1:0]  rsh;
    logic [AW-1:0]  ra;
    logic           rd;
    logic           hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HUNT;
            pre_cnt <= '0;
            bit_cnt <= '0;
            sh      <= '0;
            rsh     <= '0;
            ra      <= '0;
            rd      <= 1'b0;
            hit     <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            wr_o    <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (rise_i) begin
                case (st)
                    ST_HUNT: begin
                        if (din_i) begin
                            if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            if (pre_cnt == PCW'(PRE_LEN)) st <= ST_START;
                            pre_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        st      <= din_i ? ST_OP : ST_HUNT;
                        bit_cnt <= '0;
                    end
                    ST_OP: begin
                        sh <= {sh[DW-2:0], din_i};
                        if (bit_cnt == 0) begin
                            bit_cnt <= 1;
                        end else begin
                            bit_cnt <= '0;
                            if ({sh[0], din_i} == OP_RD) begin
                                rd <= 1'b1;
                                st <= ST_PHY;
                            end else if ({sh[0], din_i} == OP_WR) begin
                                rd <= 1'b0;
                                st <= ST_PHY;
                            end else begin
                                st <= ST_HUNT;
                            end
                        end
                    end
                    ST_PHY: begin
                        sh      <= {sh[DW-2:0], din_i};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(AW-1)) begin
                            hit     <= ({sh[AW-2:0], din_i} == phy_addr_i);
                            st      <= ST_REG;
                            bit_cnt <= '0;
                        end
                    end
                    ST_REG: begin
                        sh      <= {sh[DW-2:0], din_i};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(AW-1)) begin
                            ra      <= {sh[AW-2:0], din_i};
                            st      <= ST_TA;
                            bit_cnt <= '0;
                        end
                    end
                    ST_TA: begin
                        if (bit_cnt == 0) begin
                            bit_cnt <= 1;
                            rsh     <= rdata_i;
                            mdio_oe <= rd & hit;
                            mdio_o  <= 1'b0;
                        end else begin
                            bit_cnt <= '0;
                            st      <= ST_DATA;
                            mdio_o  <= rd & hit & rsh[DW-1];
                            rsh     <= {rsh[DW-2:0], 1'b0};
                        end
                    end
                    ST_DATA: begin
                        sh      <= {sh[DW-2:0], din_i};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(DW-1)) begin
                            st      <= ST_HUNT;
                            pre_cnt <= '0;
                            bit_cnt <= '0;
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                            if (!rd && hit && addr_impl(IMPL_MASK, ra)) begin
                                wr_o.en   <= 1'b1;
                                wr_o.addr <= ra;
                                wr_o.data <= {sh[DW-2:0], din_i};
                            end
                        end else begin
                            mdio_o <= rd & hit & rsh[DW-1];
                            rsh    <= {rsh[DW-2:0], 1'b0};
                        end
                    end
                    default: st <= ST_HUNT;
                endcase
            end
        end
    end

    assign raddr_o = ra;
    assign state_o = st;
    assign rd_o    = rd;
    assign hit_o   = hit;
endmodule

// File: rtl/mdio_slv_top.sv
module mdio_slv_top
    import mdio_slv_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 32'h0000_800F,
    parameter logic [DW-1:0]   RST_VAL   = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mdc_i,
    input  logic          mdio_i,
    input  logic [AW-1:0] phy_addr_i,
    output logic          mdio_o,
    output logic          mdio_oe
);
    logic          mdc_rise;
    logic          din;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    mdio_wr_t      wr;
    mdio_st_e      fsm_st;
    logic          op_rd;
    logic          addr_hit;

    mdio_slv_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .mdc_i  (mdc_i),
        .mdio_i (mdio_i),
        .rise_o (mdc_rise),
        .din_o  (din)
    );

    mdio_slv_fsm #(.IMPL_MASK(IMPL_MASK)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (mdc_rise),
        .din_i      (din),
        .phy_addr_i (phy_addr_i),
        .rdata_i    (rdata),
        .raddr_o    (raddr),
        .wr_o       (wr),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .state_o    (fsm_st),
        .rd_o       (op_rd),
        .hit_o      (addr_hit)
    );

    mdio_slv_regs #(.IMPL_MASK(IMPL_MASK), .RST_VAL(RST_VAL)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );
endmodule

// File: rtl/mdio_slv_chk.sv
module mdio_slv_chk
    import mdio_slv_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     mdc_rise,
    input logic     mdio_o,
    input logic     mdio_oe,
    input mdio_st_e fsm_st,
    input logic     op_rd,
    input logic     addr_hit
);
    // R11: released right after reset
    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !mdio_oe);

    // R1: driven value only moves after a sampled clock rising edge
    a_r1_change_on_edge: assert property (@(posedge clk) disable iff (rst)
        !mdc_rise |=> ($stable(mdio_oe) && $stable(mdio_o)));

    // R3: drive only in turnaround or data phase
    a_r3_drive_window: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> (fsm_st == ST_TA || fsm_st == ST_DATA));

    // R4: no drive while a write frame is in turnaround or data
    a_r4_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!op_rd && (fsm_st == ST_TA || fsm_st == ST_DATA)) |-> !mdio_oe);

    // R7: drive needs a matching PHY address
    a_r7_drive_needs_hit: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> addr_hit);

    // R9: hunting, start and opcode phases never drive
    a_r9_no_drive_early: assert property (@(posedge clk) disable iff (rst)
        (fsm_st == ST_HUNT || fsm_st == ST_START || fsm_st == ST_OP) |-> !mdio_oe);
endmodule

bind mdio_slv_top mdio_slv_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc_rise (mdc_rise),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .fsm_st   (fsm_st),
    .op_rd    (op_rd),
    .addr_hit (addr_hit)
);

// File: tb/mdio_slv_tb.sv
module mdio_slv_top_tb_top;
    localparam logic [31:0] MASK   = 32'h0000_800F;
    localparam logic [4:0]  MY_PHY = 5'h0A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mdc = 1'b0;
    logic st_en = 1'b0;
    logic st_val = 1'b1;
    logic mdio_o, mdio_oe;
    logic bus;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] model [32];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] act_word;
    event        word_done;

    always #10 clk = ~clk;

    assign bus = mdio_oe ? mdio_o : (st_en ? st_val : 1'b1);

    mdio_slv_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .mdc_i      (mdc),
        .mdio_i     (bus),
        .phy_addr_i (MY_PHY),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(input logic [4:0] a);
        return MASK[a] ? model[a] : 16'hFFFF;
    endfunction

    // monitor: pops expected read words as the bus produces them
    initial begin
        forever begin
            @(word_done);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected read word", {16'h0, act_word}, 32'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act_word === e, t, "read data", {16'h0, act_word}, {16'h0, e});
            end
        end
    end

    task automatic do_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] wd, input int pre_len, input logic [1:0] stb,
                            input int idle, input string tag);
        bit valid, drive;
        int mism;
        logic [15:0] w;
        logic [15:0] ew;
        valid = (pre_len + idle >= 32) && stb == 2'b01 && (op == 2'b10 || op == 2'b01);
        drive = valid && op == 2'b10 && phy == MY_PHY;
        ew    = model_rd(ra);
        mism  = 0;
        w     = '0;
        if (drive) begin
            exp_q.push_back(ew);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < idle + pre_len + 32; i++) begin
            int k;
            logic b;
            bit rel, eoe;
            k = i - idle - pre_len;
            if (i < idle)      b = 1'b1;
            else if (k < 0)    b = 1'b1;
            else if (k < 2)    b = stb[1-k];
            else if (k < 4)    b = op[3-k];
            else if (k < 9)    b = phy[8-k];
            else if (k < 14)   b = ra[13-k];
            else if (k < 16)   b = (k == 14);
            else               b = wd[31-k];
            rel = (i < idle) || (op == 2'b10 && k >= 14);
            eoe = drive && k >= 15;
            st_en  = !rel;
            st_val = b;
            repeat (4) @(negedge clk);
            if (mdio_oe !== eoe) mism++;
            if (k == 15 && eoe && mdio_o !== 1'b0) mism++;
            if (k >= 16) w = {w[14:0], bus};
            mdc = 1'b1;
            repeat (4) @(negedge clk);
            mdc = 1'b0;
        end
        chk(mism == 0, tag, "drive pattern mismatches", mism, 0);
        if (drive) begin
            act_word = w;
            ->word_done;
            @(negedge clk);
        end
        if (valid && op == 2'b01 && phy == MY_PHY && MASK[ra]) model[ra] = wd;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        do_frame(2'b10, MY_PHY, a, 16'h0, 32, 2'b01, 0, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
        do_frame(2'b01, MY_PHY, a, d, 32, 2'b01, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 32; a++) model[a] = 16'h0000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(mdio_oe === 1'b0, "R11", "oe after reset", {31'h0, mdio_oe}, 0);

        rd(5'd2, "R11");                              // reset value
        wr(5'd1, 16'hA5C3, "R2");
        rd(5'd1, "R1");                               // back to back, R10
        wr(5'd15, 16'h8001, "R2");
        rd(5'd15, "R3");
        rd(5'd7, "R5");
        rd(5'd30, "R5");
        wr(5'd7, 16'h1234, "R6");
        rd(5'd0, "R6"); rd(5'd1, "R6"); rd(5'd2, "R6"); rd(5'd3, "R6"); rd(5'd15, "R6");
        rd(5'd7, "R6");
        do_frame(2'b01, 5'h0B, 5'd1, 16'h0000, 32, 2'b01, 0, "R7");
        do_frame(2'b10, 5'h0B, 5'd1, 16'h0000, 32, 2'b01, 0, "R7");
        rd(5'd1, "R7");
        wr(5'd4, 16'h4444, "R4");
        do_frame(2'b01, MY_PHY, 5'd2, 16'hFFFF, 31, 2'b01, 0, "R8");
        rd(5'd2, "R8");
        do_frame(2'b11, MY_PHY, 5'd3, 16'h5A5A, 32, 2'b01, 0, "R9");
        do_frame(2'b00, MY_PHY, 5'd3, 16'h5A5A, 32, 2'b01, 0, "R9");
        do_frame(2'b01, MY_PHY, 5'd3, 16'h5A5A, 32, 2'b00, 0, "R9");
        rd(5'd3, "R9");
        wr(5'd3, 16'hC3C3, "R10");
        rd(5'd3, "R10");
        rd(5'd1, "R10");
        do_frame(2'b10, MY_PHY, 5'd3, 16'h0, 32, 2'b01, 2, "R10");
        do_frame(2'b01, MY_PHY, 5'd0, 16'h7FFE, 32, 2'b01, 0, "R2");
        rd(5'd0, "R1");

        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "read words left unseen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule